// File: doc/BRIEF.md
# Serial Converter Word Writer

This block is the controller-side master for a quad 12-bit converter that takes its commands over a three-wire serial link. A request carries a 2-bit channel select, a 2-bit device address and a 12-bit code. The block packs these into one 16-bit word and sends it as two 8-bit transfers. The active-low frame line stays asserted across both transfers and is released only after the last bit.

Inside the block, an 8-bit byte port shifts each byte out. The port can work in either bit order. When it works LSB first, each byte is mirrored before the port takes it, so the wire always carries the word MSB first. After each word the block can pulse the active-low update line. In deferred mode it holds the update back until a separate commit request arrives, so that several channels change together. A clear request pulses the active-low clear line. While any of this activity runs, a busy flag is high and new requests are refused.

Top module: `dac_frame_writer`

## Requirements
- R1: The word on the wire holds the code in bits 15..4, the address in bits 3..2 and the channel in bits 1..0. The word is sent MSB first: bit 15 is on the line at the first falling serial-clock edge of the frame.
- R2: `frameN` falls before the first rising serial-clock edge and stays low through both bytes, including the gap between them. It returns high only after the sixteenth falling edge. No falling edge occurs while `frameN` is high.
- R3: Each frame has exactly 16 falling `sclk` edges, eight per byte. `sclk` stays high for HALF_CYC system cycles per bit, and `sdata` does not change while `sclk` is high.
- R4: When `lsbFirst` is 1 at acceptance, the byte port shifts LSB first and each byte is mirrored beforehand. The wire word is then identical to the word sent with `lsbFirst` = 0.
- R5: If `deferMode` is 0 at acceptance, `updN` goes low for exactly PULSE_CYC cycles after `frameN` returns high. `busy` stays high until that pulse ends.
- R6: If `deferMode` is 1 at acceptance, the word produces no update pulse. A later `commitReq` while idle produces one `updN` pulse of PULSE_CYC cycles and no frame.
- R7: A `clearReq` while idle drives `clrN` low for PULSE_CYC cycles and sends no frame.
- R8: A request is accepted (`reqAccept` = 1, in the same cycle) only while `busy` is 0. A request made while busy raises `reqReject` and does not alter or add to the frame in progress.
- R9: In an idle cycle, a clear request beats a commit request, and a commit request beats a word request. A word request that loses is rejected.
- R10: After reset, `frameN`, `updN` and `clrN` are high, and `sclk` and `busy` are low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rstN | input | 1 | Active-low synchronous reset |
| reqValid | input | 1 | Word request |
| reqChan | input | 2 | Channel select for the word |
| reqAddr | input | 2 | Device address for the word |
| reqCode | input | 12 | Converter code |
| lsbFirst | input | 1 | Byte port shifts LSB first |
| deferMode | input | 1 | Hold update until commit |
| commitReq | input | 1 | Issue deferred update pulse |
| clearReq | input | 1 | Issue clear pulse |
| reqAccept | output | 1 | Request taken this cycle |
| reqReject | output | 1 | Request refused this cycle |
| busy | output | 1 | Frame or pulse in progress |
| sclk | output | 1 | Serial clock, idles low |
| sdata | output | 1 | Serial data |
| frameN | output | 1 | Active-low frame |
| updN | output | 1 | Active-low update pulse |
| clrN | output | 1 | Active-low clear pulse |

## Verification
A word request can fall in the same idle cycle as a clear or a commit request. It can also fall in a cycle where the block is still busy. The bench raises each pair in a single cycle and checks the one-cycle accept and reject outputs. It then watches the pins until the block is idle again. The winning pulse must appear with its full length, and the frame count must not change. A word request sent during a frame must leave that frame's decoded word intact.

// File: rtl/fw_pkg.sv
package fw_pkg;

  typedef struct packed {
    logic loadWord;
    logic loadLow;
    logic shiftBit;
  } fwStrobes_t;

  typedef enum logic [2:0] {
    S_IDLE, S_LEAD, S_HI, S_LO, S_GAP, S_TAIL, S_UPD, S_CLR
  } fwState_t;

endpackage

// File: rtl/fw_datapath.sv
module fw_datapath
  import fw_pkg::*;
#(
  parameter int CODE_W = 12,
  parameter int ADDR_W = 2,
  parameter int CHAN_W = 2,
  parameter int BYTE_W = 8
) (
  input  logic              clk,
  input  logic              rstN,
  input  fwStrobes_t        strb,
  input  logic              lsbFirst,
  input  logic [CHAN_W-1:0] chan,
  input  logic [ADDR_W-1:0] addr,
  input  logic [CODE_W-1:0] code,
  output logic              sdata
);
  localparam int WORD_W = CODE_W + ADDR_W + CHAN_W;

  logic [WORD_W-1:0] wordReg;
  logic [WORD_W-1:0] packedW;
  logic [BYTE_W-1:0] shReg;
  logic              modeLsb;
  logic              sdataR;

  function automatic logic [BYTE_W-1:0] mirror(input logic [BYTE_W-1:0] b);
    logic [BYTE_W-1:0] r;
    for (int i = 0; i < BYTE_W; i++) r[i] = b[BYTE_W-1-i];
    return r;
  endfunction

  // Code in the upper bits, then device address, then channel select
  assign packedW = {code, addr, chan};

  always_ff @(posedge clk) begin
    if (!rstN) begin
      wordReg <= '0;
      shReg   <= '0;
      modeLsb <= 1'b0;
      sdataR  <= 1'b0;
    end else if (strb.loadWord) begin
      wordReg <= packedW;
      modeLsb <= lsbFirst;
      shReg   <= lsbFirst ? mirror(packedW[WORD_W-1 -: BYTE_W])
                          : packedW[WORD_W-1 -: BYTE_W];
    end else if (strb.loadLow) begin
      shReg <= modeLsb ? mirror(wordReg[BYTE_W-1:0]) : wordReg[BYTE_W-1:0];
    end else if (strb.shiftBit) begin
      if (modeLsb) begin
        sdataR <= shReg[0];
        shReg  <= shReg >> 1;
      end else begin
        sdataR <= shReg[BYTE_W-1];
        shReg  <= shReg << 1;
      end
    end
  end

  assign sdata = sdataR;

endmodule

// File: rtl/fw_control.sv
module fw_control
  import fw_pkg::*;
#(
  parameter int HALF_CYC  = 5,
  parameter int PULSE_CYC = 4,
  parameter int BYTE_W    = 8
) (
  input  logic       clk,
  input  logic       rstN,
  input  logic       reqValid,
  input  logic       deferMode,
  input  logic       commitReq,
  input  logic       clearReq,
  output fwStrobes_t strb,
  output logic       reqAccept,
  output logic       reqReject,
  output logic       busy,
  output logic       sclk,
  output logic       frameN,
  output logic       updN,
  output logic       clrN
);
  localparam int TMAX = (HALF_CYC > PULSE_CYC) ? HALF_CYC : PULSE_CYC;
  localparam int TW   = $clog2(TMAX + 1);
  localparam int BW   = $clog2(BYTE_W);

  fwState_t         state, nextState;
  logic [TW-1:0]    timer;
  logic [BW-1:0]    bitCnt;
  logic             lowByte;
  logic             deferLat;
  logic             timerDone;

  assign timerDone = (timer == '0);

  always_comb begin
    nextState = state;
    strb      = '0;
    unique case (state)
      S_IDLE: begin
        if (clearReq)       nextState = S_CLR;
        else if (commitReq) nextState = S_UPD;
        else if (reqValid) begin
          nextState     = S_LEAD;
          strb.loadWord = 1'b1;
        end
      end
      S_LEAD: if (timerDone) begin
        nextState     = S_HI;
        strb.shiftBit = 1'b1;
      end
      S_HI: if (timerDone) nextState = S_LO;
      S_LO: if (timerDone) begin
        if (bitCnt == BW'(BYTE_W - 1)) begin
          if (!lowByte) begin
            nextState    = S_GAP;
            strb.loadLow = 1'b1;
          end else begin
            nextState = S_TAIL;
          end
        end else begin
          nextState     = S_HI;
          strb.shiftBit = 1'b1;
        end
      end
      S_GAP: if (timerDone) begin
        nextState     = S_HI;
        strb.shiftBit = 1'b1;
      end
      S_TAIL: if (timerDone) nextState = deferLat ? S_IDLE : S_UPD;
      S_UPD:  if (timerDone) nextState = S_IDLE;
      S_CLR:  if (timerDone) nextState = S_IDLE;
      default: nextState = S_IDLE;
    endcase
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      state    <= S_IDLE;
      timer    <= '0;
      bitCnt   <= '0;
      lowByte  <= 1'b0;
      deferLat <= 1'b0;
    end else begin
      state <= nextState;
      if (nextState != state)
        timer <= (nextState == S_UPD || nextState == S_CLR) ? TW'(PULSE_CYC - 1)
                                                             : TW'(HALF_CYC - 1);
      else if (!timerDone)
        timer <= timer - 1'b1;
      if (strb.loadWord || strb.loadLow)
        bitCnt <= '0;
      else if (state == S_LO && nextState == S_HI)
        bitCnt <= bitCnt + 1'b1;
      if (strb.loadWord) begin
        lowByte  <= 1'b0;
        deferLat <= deferMode;
      end else if (strb.loadLow) begin
        lowByte <= 1'b1;
      end
    end
  end

  assign busy      = (state != S_IDLE);
  assign reqAccept = strb.loadWord;
  assign reqReject = reqValid && !strb.loadWord;
  assign sclk      = (state == S_HI);
  assign frameN    = !(state inside {S_LEAD, S_HI, S_LO, S_GAP, S_TAIL});
  assign updN      = (state != S_UPD);
  assign clrN      = (state != S_CLR);

  // R8
  busy_reject_chk: assert property (@(posedge clk) disable iff (!rstN)
    (busy && reqValid) |-> (!reqAccept && reqReject));

  // R9
  req_priority_chk: assert property (@(posedge clk) disable iff (!rstN)
    reqAccept |-> (!clearReq && !commitReq));

  // R7
  clr_origin_chk: assert property (@(posedge clk) disable iff (!rstN)
    $fell(clrN) |-> $past(clearReq));

  // R6
  defer_update_chk: assert property (@(posedge clk) disable iff (!rstN)
    ($fell(updN) && !$past(commitReq)) |-> !$past(deferLat));

endmodule

// File: rtl/dac_frame_writer.sv
module dac_frame_writer
  import fw_pkg::*;
#(
  parameter int CODE_W    = 12,
  parameter int ADDR_W    = 2,
  parameter int CHAN_W    = 2,
  parameter int BYTE_W    = 8,
  parameter int HALF_CYC  = 5,
  parameter int PULSE_CYC = 4
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              reqValid,
  input  logic [CHAN_W-1:0] reqChan,
  input  logic [ADDR_W-1:0] reqAddr,
  input  logic [CODE_W-1:0] reqCode,
  input  logic              lsbFirst,
  input  logic              deferMode,
  input  logic              commitReq,
  input  logic              clearReq,
  output logic              reqAccept,
  output logic              reqReject,
  output logic              busy,
  output logic              sclk,
  output logic              sdata,
  output logic              frameN,
  output logic              updN,
  output logic              clrN
);
  fwStrobes_t strb;

  fw_control #(.HALF_CYC(HALF_CYC), .PULSE_CYC(PULSE_CYC), .BYTE_W(BYTE_W)) uCtrl (
    .clk(clk), .rstN(rstN), .reqValid(reqValid), .deferMode(deferMode),
    .commitReq(commitReq), .clearReq(clearReq), .strb(strb),
    .reqAccept(reqAccept), .reqReject(reqReject), .busy(busy),
    .sclk(sclk), .frameN(frameN), .updN(updN), .clrN(clrN)
  );

  fw_datapath #(.CODE_W(CODE_W), .ADDR_W(ADDR_W), .CHAN_W(CHAN_W), .BYTE_W(BYTE_W)) uData (
    .clk(clk), .rstN(rstN), .strb(strb), .lsbFirst(lsbFirst),
    .chan(reqChan), .addr(reqAddr), .code(reqCode), .sdata(sdata)
  );

  // R3
  data_stable_chk: assert property (@(posedge clk) disable iff (!rstN)
    (sclk && $past(sclk)) |-> $stable(sdata));

  // R2
  frame_edge_chk: assert property (@(posedge clk) disable iff (!rstN)
    $fell(sclk) |-> !frameN);

endmodule

// File: tb/tb_dac_frame_writer.sv
`timescale 1ns/1ps
module tb_dac_frame_writer;
  localparam int CLK_PERIOD = 10;
  localparam int HALF = 5;
  localparam int PULSE = 4;

  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic reqValid = 1'b0, lsbFirst = 1'b0, deferMode = 1'b0, commitReq = 1'b0, clearReq = 1'b0;
  logic [1:0] reqChan = '0, reqAddr = '0;
  logic [11:0] reqCode = '0;
  logic reqAccept, reqReject, busy, sclk, sdata, frameN, updN, clrN;

  int nChecks = 0, nFails = 0;
  bit done = 1'b0;

  always #(CLK_PERIOD/2) clk = ~clk;

  dac_frame_writer #(.HALF_CYC(HALF), .PULSE_CYC(PULSE)) dut (
    .clk(clk), .rstN(rstN), .reqValid(reqValid), .reqChan(reqChan), .reqAddr(reqAddr),
    .reqCode(reqCode), .lsbFirst(lsbFirst), .deferMode(deferMode), .commitReq(commitReq),
    .clearReq(clearReq), .reqAccept(reqAccept), .reqReject(reqReject), .busy(busy),
    .sclk(sclk), .sdata(sdata), .frameN(frameN), .updN(updN), .clrN(clrN)
  );

  // pin monitor, sampled on the falling system clock edge
  logic prevSclk = 0, prevFrame = 1, prevUpd = 1, prevClr = 1, prevSdata = 0;
  logic [15:0] shiftIn = '0, lastWord = '0;
  int fallCnt = 0, lastFalls = 0, frames = 0, strayFalls = 0;
  int highRun = 0, badHigh = 0, unstable = 0;
  int updRun = 0, lastUpdLen = 0, updPulses = 0;
  int clrRun = 0, lastClrLen = 0, clrPulses = 0;

  always @(negedge clk) begin
    if (rstN) begin
      if (sclk) begin
        highRun++;
        if (prevSclk && sdata != prevSdata) unstable++;
      end
      if (prevSclk && !sclk) begin
        if (highRun != HALF) badHigh++;
        highRun = 0;
        if (frameN) strayFalls++;
        shiftIn = {shiftIn[14:0], sdata};
        fallCnt++;
      end
      if (prevFrame && !frameN) begin fallCnt = 0; shiftIn = '0; end
      if (!prevFrame && frameN) begin lastWord = shiftIn; lastFalls = fallCnt; frames++; end
      if (!updN) updRun++;
      if (!prevUpd && updN) begin lastUpdLen = updRun; updRun = 0; updPulses++; end
      if (!clrN) clrRun++;
      if (!prevClr && clrN) begin lastClrLen = clrRun; clrRun = 0; clrPulses++; end
    end
    prevSclk = sclk; prevFrame = frameN; prevUpd = updN; prevClr = clrN; prevSdata = sdata;
  end

  task automatic check(input bit ok, input string tag, input int act, input int exp);
    nChecks++;
    if (!ok) begin
      nFails++;
      $display("FAIL %s actual=0x%0h expected=0x%0h", tag, act, exp);
    end
  endtask

  task automatic waitIdle();
    while (busy) @(negedge clk);
    #(CLK_PERIOD*2);
  endtask

  task automatic sendWord(input logic [1:0] ch, input logic [1:0] ad, input logic [11:0] cd,
                          input logic lsb, input logic dfr);
    int f0, u0;
    logic [15:0] expW;
    f0 = frames; u0 = updPulses;
    expW = {cd, ad, ch};
    @(negedge clk);
    reqChan = ch; reqAddr = ad; reqCode = cd; lsbFirst = lsb; deferMode = dfr; reqValid = 1'b1;
    #1 check(reqAccept == 1'b1 && reqReject == 1'b0, "R8 idle accept", reqAccept, 1);
    @(negedge clk);
    reqValid = 1'b0;
    check(busy == 1'b1, "R5 busy after accept", busy, 1);
    waitIdle();
    check(frames == f0 + 1, "R2 one frame", frames - f0, 1);
    // R1 and R4: decoded word matches the packed fields in both port modes
    check(lastWord == expW, lsb ? "R4 mirrored word" : "R1 word layout", lastWord, expW);
    check(lastFalls == 16, "R3 falling edges", lastFalls, 16);
    if (dfr) check(updPulses == u0, "R6 no update when deferred", updPulses - u0, 0);
    else begin
      check(updPulses == u0 + 1, "R5 update pulse count", updPulses - u0, 1);
      check(lastUpdLen == PULSE, "R5 update width", lastUpdLen, PULSE);
    end
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      nChecks++; nFails++;
      $display("FAIL watchdog expired actual=1 expected=0");
      $display("  *** SUMMARY: %0d compared / %0d mismatched ***", nChecks, nFails);
      $finish;
    end
  end

  initial begin
    int f0, u0, c0;
    repeat (3) @(negedge clk);
    // R10 reset state
    check(frameN && updN && clrN && !sclk && !busy, "R10 reset state",
          {frameN, updN, clrN, sclk, busy}, 5'b11100);
    @(negedge clk) rstN = 1'b1;
    repeat (2) @(negedge clk);

    // R1 R4 R5: sweep every channel, address and port mode
    for (int l = 0; l < 2; l++)
      for (int c = 0; c < 4; c++)
        for (int a = 0; a < 4; a++)
          sendWord(2'(c), 2'(a), 12'((c*733 + a*1291 + l*1777 + 5) & 12'hFFF), 1'(l), 1'b0);
    sendWord(2'd3, 2'd2, 12'h000, 1'b0, 1'b0);
    sendWord(2'd3, 2'd2, 12'hFFF, 1'b1, 1'b0);
    sendWord(2'd0, 2'd1, 12'hA5C, 1'b1, 1'b0);
    // R2 R3 pin discipline over the whole sweep
    check(strayFalls == 0, "R2 falls outside frame", strayFalls, 0);
    check(badHigh == 0, "R3 sclk high time", badHigh, 0);
    check(unstable == 0, "R3 sdata stable while sclk high", unstable, 0);

    // R6 deferred batch then commit
    u0 = updPulses;
    for (int c = 0; c < 4; c++) sendWord(2'(c), 2'd1, 12'(c*1000 + 7), 1'(c & 1), 1'b1);
    f0 = frames;
    @(negedge clk) commitReq = 1'b1;
    @(negedge clk) commitReq = 1'b0;
    waitIdle();
    check(updPulses == u0 + 1, "R6 single commit pulse", updPulses - u0, 1);
    check(lastUpdLen == PULSE, "R6 commit width", lastUpdLen, PULSE);
    check(frames == f0, "R6 commit sends no frame", frames - f0, 0);

    // R7 clear
    c0 = clrPulses; f0 = frames;
    @(negedge clk) clearReq = 1'b1;
    @(negedge clk) clearReq = 1'b0;
    waitIdle();
    check(clrPulses == c0 + 1, "R7 clear pulse", clrPulses - c0, 1);
    check(lastClrLen == PULSE, "R7 clear width", lastClrLen, PULSE);
    check(frames == f0, "R7 clear sends no frame", frames - f0, 0);

    // R8 request while busy
    f0 = frames;
    @(negedge clk);
    reqChan = 2'd2; reqAddr = 2'd3; reqCode = 12'h3C1; lsbFirst = 0; deferMode = 1; reqValid = 1;
    @(negedge clk) reqValid = 1'b0;
    repeat (20) @(negedge clk);
    reqChan = 2'd1; reqAddr = 2'd0; reqCode = 12'hFFF; reqValid = 1'b1;
    #1 check(reqReject == 1'b1 && reqAccept == 1'b0, "R8 busy reject", reqReject, 1);
    @(negedge clk) reqValid = 1'b0;
    waitIdle();
    check(frames == f0 + 1, "R8 no extra frame", frames - f0, 1);
    check(lastWord == {12'h3C1, 2'd3, 2'd2}, "R8 frame intact", lastWord, {12'h3C1, 2'd3, 2'd2});

    // R9 clear and request in the same cycle
    c0 = clrPulses; f0 = frames;
    @(negedge clk);
    clearReq = 1'b1; reqValid = 1'b1; deferMode = 0;
    #1 check(reqAccept == 1'b0 && reqReject == 1'b1, "R9 clear beats request", reqAccept, 0);
    @(negedge clk) begin clearReq = 1'b0; reqValid = 1'b0; end
    waitIdle();
    check(clrPulses == c0 + 1 && frames == f0, "R9 clear only", clrPulses - c0, 1);

    // R9 commit and request in the same cycle
    u0 = updPulses; f0 = frames;
    @(negedge clk);
    commitReq = 1'b1; reqValid = 1'b1;
    #1 check(reqAccept == 1'b0 && reqReject == 1'b1, "R9 commit beats request", reqAccept, 0);
    @(negedge clk) begin commitReq = 1'b0; reqValid = 1'b0; end
    waitIdle();
    check(updPulses == u0 + 1 && frames == f0, "R9 commit only", updPulses - u0, 1);

    // R9 clear and commit together: clear wins
    u0 = updPulses; c0 = clrPulses;
    @(negedge clk) begin clearReq = 1'b1; commitReq = 1'b1; end
    @(negedge clk) begin clearReq = 1'b0; commitReq = 1'b0; end
    waitIdle();
    check(clrPulses == c0 + 1 && updPulses == u0, "R9 clear beats commit", updPulses - u0, 0);

    done = 1'b1;
    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", nChecks, nFails);
    $finish;
  end

endmodule